// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block owns the operating state of a serial shift engine. Software asks for one of three states (idle/reset, run, pause) by writing a two-bit code into a state register. The block takes a fixed number of cycles to move there, and it clears a valid flag for that whole time. The flag comes back when the new state has taken effect, so software can poll one readable word to learn both the current state and whether the last request has finished. The delay models a crossing into the engine's clock domain and back: a fixed number of register-side cycles, then a fixed number of engine-side cycles.

A separate soft-reset write forces the block into the idle state at once, even during a transition, and then runs a normal handshake before valid returns. The outputs enable or freeze the downstream engine. A small position tracker stands in for the engine's queue pointer. It advances on each item taken while running, holds its value while paused, and is cleared while idle. A sticky error-interrupt flag is cleared when software requests the idle state or issues a soft reset. The readable word also shows whether the core is strapped as a bus master.

Top module: `rsc_run_ctrl`

## Requirements
- R1: After asynchronous reset the state code is 0 (idle), valid is 1, the error flag is 0 and the position is 0. The read word is {3'b0, master, 1'b0, valid, state[1:0]}, which gives 8'h04 or 8'h14.
- R2: A state write (wr_sel_i=0) with code 0, 1 or 3 while valid is 1 is accepted. Valid reads 0 from the next cycle for HOST_DLY+ENG_DLY cycles in total (6 by default). It then reads 1 with the state code equal to the requested code.
- R3: While valid is 0, the state code keeps its old value until the cycle in which valid returns to 1.
- R4: A state write that arrives while valid is 0 is ignored. It neither changes the target state nor extends the transition.
- R5: A state write of the unused code 2 while valid is 1 changes nothing: valid stays 1 and the state code is unchanged.
- R6: Bit 4 of the read word follows master_cfg_i. Bits 3 and 7:5 always read 0.
- R7: A write with wr_sel_i=1 and wr_data_i[0]=1 sets the state code to 0 and valid to 0 from the next cycle, even during a transition. Valid returns to 1 after HOST_DLY+ENG_DLY cycles with the state still 0. A write with wr_sel_i=1 and wr_data_i[0]=0 has no effect.
- R8: An accepted state write of code 0, or a soft reset, clears the error flag. Accepted writes of code 1 or 3 leave it set.
- R9: In the run state (code 1), eng_run_o is 1, pop_o equals item_avail_i, and pos_o advances by one, modulo 2^POS_W, for every cycle with pop_o high.
- R10: In the pause state (code 3), eng_hold_o is 1, pop_o is 0 and pos_o holds its value.
- R11: In the idle state (code 0), pop_o is 0 and pos_o is cleared to 0 on the next clock edge.
- R12: A pulse on err_set_i sets err_irq_o from the next cycle, and it stays set until it is cleared as R8 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: state register, 1: soft-reset register |
| wr_data_i | input | 2 | Write data: state code, or bit 0 for soft reset |
| master_cfg_i | input | 1 | Core strapped as bus master |
| err_set_i | input | 1 | Error event pulse |
| item_avail_i | input | 1 | Engine queue has an item |
| rd_data_o | output | 8 | Readable state word |
| err_irq_o | output | 1 | Sticky error interrupt |
| eng_run_o | output | 1 | Engine enabled |
| eng_hold_o | output | 1 | Engine frozen |
| pop_o | output | 1 | Engine takes one queue item |
| pos_o | output | POS_W | Engine queue position |

## Verification
The bench sweeps every pair of source state and requested code. It checks every cycle of each handshake, which catches a window that is off by one or a state that commits too early. Late requests are placed at each cycle offset inside a transition, so a design that accepted them would end in the wrong state or leave valid low for too long. Soft resets are placed at every offset, including the commit cycle, where a design with the wrong priority would commit the old target instead of idle. Position checks across the run, pause and idle states catch a pointer that drifts while paused, or one that is not cleared when the block goes idle.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_RSVD  = 2'd2,
    ST_PAUSE = 2'd3
  } run_st_e;
endpackage

// File: rtl/rsc_delay_line.sv
module rsc_delay_line #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic in_i,
  output logic out_o
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= in_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (flush_i) sr_q <= {{(DEPTH-1){1'b0}}, in_i};
        else              sr_q <= {sr_q[DEPTH-2:0], in_i};
      end
    end
  endgenerate

  assign out_o = sr_q[DEPTH-1];
endmodule

// File: rtl/rsc_engine_pos.sv
module rsc_engine_pos
  import rsc_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  run_st_e          state_i,
  input  logic             avail_i,
  output logic             pop_o,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q;

  assign pop_o = (state_i == ST_RUN) && avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pos_q <= '0;
    else if (state_i == ST_IDLE) pos_q <= '0;
    else if (pop_o)              pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/rsc_run_ctrl.sv
module rsc_run_ctrl
  import rsc_pkg::*;
#(
  parameter int HOST_DLY = 3,
  parameter int ENG_DLY  = 3,
  parameter int POS_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [1:0]       wr_data_i,
  input  logic             master_cfg_i,
  input  logic             err_set_i,
  input  logic             item_avail_i,
  output logic [7:0]       rd_data_o,
  output logic             err_irq_o,
  output logic             eng_run_o,
  output logic             eng_hold_o,
  output logic             pop_o,
  output logic [POS_W-1:0] pos_o
);
  run_st_e cur_q, tgt_q;
  logic    valid_q, err_q;
  logic    soft_rst, accept, host_out, done;
  run_st_e req;

  assign req      = run_st_e'(wr_data_i);
  assign soft_rst = wr_en_i && wr_sel_i && wr_data_i[0];
  assign accept   = wr_en_i && !wr_sel_i && valid_q && (req != ST_RSVD);

  // register-side stage, then engine-side stage
  rsc_delay_line #(.DEPTH(HOST_DLY)) u_host_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(soft_rst),
    .in_i(accept || soft_rst), .out_o(host_out)
  );
  rsc_delay_line #(.DEPTH(ENG_DLY)) u_eng_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(soft_rst),
    .in_i(host_out && !soft_rst), .out_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= ST_IDLE;
      tgt_q   <= ST_IDLE;
      valid_q <= 1'b1;
    end else if (soft_rst) begin
      cur_q   <= ST_IDLE;
      tgt_q   <= ST_IDLE;
      valid_q <= 1'b0;
    end else if (done) begin
      cur_q   <= tgt_q;
      valid_q <= 1'b1;
    end else if (accept) begin
      tgt_q   <= req;
      valid_q <= 1'b0;
    end
  end

  // clear beats set on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 err_q <= 1'b0;
    else if (soft_rst || (accept && req == ST_IDLE)) err_q <= 1'b0;
    else if (err_set_i)                          err_q <= 1'b1;
  end

  rsc_engine_pos #(.POS_W(POS_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(cur_q),
    .avail_i(item_avail_i), .pop_o(pop_o), .pos_o(pos_o)
  );

  assign rd_data_o  = {3'b000, master_cfg_i, 1'b0, valid_q, cur_q};
  assign err_irq_o  = err_q;
  assign eng_run_o  = (cur_q == ST_RUN);
  assign eng_hold_o = (cur_q == ST_PAUSE);
endmodule

// File: rtl/rsc_run_ctrl_chk.sv
module rsc_run_ctrl_chk #(
  parameter int POS_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [1:0]       wr_data_i,
  input logic             err_set_i,
  input logic             item_avail_i,
  input logic [7:0]       rd_data_o,
  input logic             err_irq_o,
  input logic             eng_run_o,
  input logic             eng_hold_o,
  input logic             pop_o,
  input logic [POS_W-1:0] pos_o
);
  logic st_wr, sr_wr;
  assign st_wr = wr_en_i && !wr_sel_i;
  assign sr_wr = wr_en_i && wr_sel_i && wr_data_i[0];

  p_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wr_data_i != 2'd2 && rd_data_o[2]) |=> !rd_data_o[2]);
  p_hold_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[2] && !sr_wr) |=> (rd_data_o[2] || $stable(rd_data_o[1:0])));
  p_rsvd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && !sr_wr && wr_data_i == 2'd2 && rd_data_o[2]) |=> (rd_data_o[2] && $stable(rd_data_o[1:0])));
  p_fixed_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[3] == 1'b0 && rd_data_o[7:5] == 3'b000));
  p_soft_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr |=> (rd_data_o[1:0] == 2'd0 && !rd_data_o[2]));
  p_err_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wr_data_i == 2'd0 && rd_data_o[2]) |=> !err_irq_o);
  p_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_run_o && item_avail_i) |-> pop_o);
  p_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_hold_o |=> ($stable(pos_o) || !eng_hold_o || rd_data_o[1:0] != 2'd3));
  p_nopop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_hold_o |-> !pop_o);
  p_idle_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1:0] == 2'd0) |=> (pos_o == '0));
  p_err_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i && !sr_wr && !(st_wr && wr_data_i == 2'd0 && rd_data_o[2])) |=> err_irq_o);
endmodule

bind rsc_run_ctrl rsc_run_ctrl_chk #(.POS_W(POS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .err_set_i(err_set_i), .item_avail_i(item_avail_i),
  .rd_data_o(rd_data_o), .err_irq_o(err_irq_o), .eng_run_o(eng_run_o),
  .eng_hold_o(eng_hold_o), .pop_o(pop_o), .pos_o(pos_o)
);

// File: tb/rsc_run_ctrl_test.sv
module rsc_run_ctrl_test;
  localparam int HOST = 3, ENG = 3, PW = 4;
  localparam int LAT = HOST + ENG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, master = 0, err_set = 0, avail = 0;
  logic [1:0] wr_data = 0;
  logic [7:0] rd;
  logic err_irq, run, hold, pop;
  logic [PW-1:0] pos;
  int n_chk = 0, n_fail = 0;
  logic [1:0] cur_m = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rsc_run_ctrl #(.HOST_DLY(HOST), .ENG_DLY(ENG), .POS_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .master_cfg_i(master), .err_set_i(err_set),
    .item_avail_i(avail), .rd_data_o(rd), .err_irq_o(err_irq),
    .eng_run_o(run), .eng_hold_o(hold), .pop_o(pop), .pos_o(pos)
  );

  function automatic int exp_rd(input logic [1:0] st, input logic v);
    return {3'b000, master, 1'b0, v, st};
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic go(input logic [1:0] s);
    if (s != cur_m) begin
      wr(0, s);
      repeat (LAT) tick;
      cur_m = s;
    end
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); avail = 1; #1;
      chk(pop, run, "R9/R10 pop");
      @(posedge clk); #1;
    end
    @(negedge clk); avail = 0;
  endtask

  initial begin
    logic [1:0] froms [3] = '{2'd0, 2'd1, 2'd3};
    #7 rst_n = 1;
    #1;
    // R1
    chk(rd, 8'h04, "R1 read word");
    chk(err_irq, 0, "R1 err");
    chk(pos, 0, "R1 pos");
    // R6
    master = 1; #1;
    chk(rd, 8'h14, "R6 master bit");
    master = 0; #1;
    chk(rd, 8'h04, "R6 master clear");

    // R2 R3 R5 sweep: every source state x every code
    for (int f = 0; f < 3; f++) begin
      for (int t = 0; t < 4; t++) begin
        go(froms[f]);
        wr(0, 2'(t));
        if (t == 2) begin
          chk(rd, exp_rd(froms[f], 1), "R5 rsvd code");
          tick;
          chk(rd, exp_rd(froms[f], 1), "R5 rsvd later");
        end else begin
          chk(rd, exp_rd(froms[f], 0), "R2 valid drop");
          for (int c = 1; c < LAT; c++) begin
            tick;
            chk(rd, exp_rd(froms[f], 0), "R3 old state held");
          end
          tick;
          chk(rd, exp_rd(2'(t), 1), "R2 commit");
          cur_m = 2'(t);
        end
      end
    end

    // R4: late request at every offset inside a transition
    for (int off = 1; off < LAT; off++) begin
      go(0);
      wr(0, 2'd1);
      repeat (off - 1) tick;
      wr(0, 2'd3);
      repeat (LAT - off) tick;
      chk(rd, exp_rd(2'd1, 1), "R4 ignored late write");
      repeat (LAT) tick;
      chk(rd, exp_rd(2'd1, 1), "R4 no deferred commit");
      cur_m = 1;
    end

    // R7: soft reset at every offset, including the commit edge
    for (int off = 0; off < LAT; off++) begin
      go(3);
      wr(0, 2'd1);
      repeat (off) tick;
      wr(1, 2'd1);
      chk(rd, exp_rd(2'd0, 0), "R7 soft reset immediate");
      for (int c = 1; c < LAT; c++) begin
        tick;
        chk(rd, exp_rd(2'd0, 0), "R7 valid low");
      end
      tick;
      chk(rd, exp_rd(2'd0, 1), "R7 valid back");
      repeat (LAT) tick;
      chk(rd, exp_rd(2'd0, 1), "R7 stays idle");
      cur_m = 0;
    end
    go(1);
    wr(1, 2'd0);
    chk(rd, exp_rd(2'd1, 1), "R7 zero write no effect");

    // R9 R10 R11: position tracking
    go(0);
    tick;
    chk(pos, 0, "R11 pos idle");
    go(1);
    feed(5);
    chk(pos, 5, "R9 pos after run");
    go(3);
    chk(hold, 1, "R10 hold out");
    feed(3);
    chk(pos, 5, "R10 pos frozen");
    go(1);
    feed(13);
    chk(pos, 2, "R9 pos wraps");
    go(0);
    @(negedge clk); avail = 1; #1;
    chk(pop, 0, "R11 no pop idle");
    avail = 0;
    tick;
    chk(pos, 0, "R11 pos cleared");

    // R12 R8: error flag
    @(negedge clk); err_set = 1;
    @(posedge clk); #1; err_set = 0;
    chk(err_irq, 1, "R12 err set");
    repeat (3) tick;
    chk(err_irq, 1, "R12 err sticky");
    go(1);
    chk(err_irq, 1, "R8 run keeps err");
    go(3);
    chk(err_irq, 1, "R8 pause keeps err");
    go(0);
    chk(err_irq, 0, "R8 idle clears err");
    @(negedge clk); err_set = 1;
    @(posedge clk); #1; err_set = 0;
    wr(1, 2'd1);
    chk(err_irq, 0, "R8 soft reset clears err");
    repeat (LAT) tick;
    cur_m = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    finished = 1;
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule